// File: doc/BRIEF.md
# Arbitrated Dual-Port Word Memory

This block is a clocked two-port memory of 16-bit words. A left port and a right port each carry an address, write data, a write strobe, an output enable, separate upper and lower byte-lane enables and a pair of chip enables. Both ports may operate in the same cycle. When they land on the same word and at least one of them writes, the block arbitrates: the left port wins and the right port sees a busy flag and loses its write. A strap input chooses between master operation, where the busy flags are computed here and driven out, and slave operation, where busy comes in from a master device and blocks writes. Several devices can thus be cascaded side by side for wider words, with one master making the decision for all of them.

Two small side channels let the ports talk to each other. A mailbox interrupt flag per port is raised when the opposite port writes a fixed word near the top of the array and dropped when the owning port reads that word. A bank of eight hardware semaphore bits sits in its own address space, reached with a per-port select pin. Each bit can be owned by at most one port at a time.

All pins are plain level signals sampled on the rising clock edge; there is no valid/ready handshake and no back-pressure apart from the busy flag, which only discards a losing write and never stalls a port.

Top module: `dpram_arb_top`

## Requirements
- R1: A port is selected only when both of its chip enables are high; an unselected port writes nothing and its read data register keeps its last value.
- R2: A write stores only the byte lanes whose enable is high (upper lane = bits 15:8, lower lane = bits 7:0); disabled lanes keep their old contents.
- R3: A read returns the addressed word on that port's read data one cycle after the access edge, with disabled byte lanes returned as zero; while output enable is low the read data is zero, and raising it again shows the held word.
- R4: Both ports may read the same word in the same cycle; each gets the word and no busy flag rises.
- R5: In master mode, when both ports are selected on the same address in the same cycle and at least one writes, the right busy output is high in that cycle, the left busy output stays low, the left write is stored and the right write is dropped; accesses to different addresses raise no busy.
- R6: A read that coincides with a write from the other port to the same word returns the word as it was before that write.
- R7: In slave mode both busy outputs stay low, and a port whose busy input is high has its write dropped in that cycle.
- R8: A stored left-port write to the highest address (DEPTH-1) raises the right interrupt flag on the next cycle; a right-port read of that address clears it.
- R9: A stored right-port write to address DEPTH-2 raises the left interrupt flag on the next cycle; a left-port read of that address clears it.
- R10: With the semaphore select high, address bits 2:0 pick one of eight bits; writing data bit 0 = 0 requests it and grants it only if the other port does not own it; a read returns 16'h0000 if the reading port owns the bit and 16'h0001 otherwise.
- R11: Writing data bit 0 = 1 releases a bit the port owns, after which the other port can be granted it.
- R12: When both ports request the same free semaphore bit in one cycle, the left port is granted it.
- R13: After reset both read data outputs, both busy outputs and both interrupt flags are zero and every semaphore bit is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | High: busy computed and driven; low: busy taken from inputs |
| l_ce0 | input | 1 | Left chip enable 0 (active high) |
| l_ce1 | input | 1 | Left chip enable 1 (active high) |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_ube | input | 1 | Left upper byte lane enable |
| l_lbe | input | 1 | Left lower byte lane enable |
| l_sem | input | 1 | Left semaphore space select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_busy_in | input | 1 | Left busy input (slave mode) |
| l_busy_o | output | 1 | Left busy output (master mode) |
| l_int | output | 1 | Left mailbox interrupt flag |
| r_ce0 | input | 1 | Right chip enable 0 (active high) |
| r_ce1 | input | 1 | Right chip enable 1 (active high) |
| r_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable |
| r_ube | input | 1 | Right upper byte lane enable |
| r_lbe | input | 1 | Right lower byte lane enable |
| r_sem | input | 1 | Right semaphore space select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_busy_in | input | 1 | Right busy input (slave mode) |
| r_busy_o | output | 1 | Right busy output (master mode) |
| r_int | output | 1 | Right mailbox interrupt flag |

## Verification
Busy is combinational, so the bench drives a cycle's inputs just after a falling edge and reads the busy outputs a moment later in that same cycle. Read data and semaphore answers come from registers loaded on the access edge, so they are read at the falling edge that follows it, one cycle after the stimulus, while the output-enable gate is checked with no clock edge in between. Interrupt flags and stored words are likewise due one cycle after the write edge and are checked at the next falling edge or through a later read.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int WORD_W    = 16;
  localparam int LANE_W    = 8;
  localparam int SEM_N     = 8;
  localparam int SEM_IDX_W = $clog2(SEM_N);

  // decoded per-port control for one cycle
  typedef struct packed {
    logic mem_acc;  // both enables high, main array
    logic sem_acc;  // both enables high, semaphore space
    logic we;
    logic ube;
    logic lbe;
  } port_ctl_t;

  function automatic logic [WORD_W-1:0] lane_mask(input logic ube, input logic lbe);
    return {{LANE_W{ube}}, {LANE_W{lbe}}};
  endfunction
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       master,
  input  port_ctl_t [1:0]            ctl_v,
  input  logic [1:0][ADDR_W-1:0]     addr_v,
  input  logic [1:0]                 busy_in,
  output logic [1:0]                 busy_o,
  output logic [1:0]                 block
);
  logic same_word;
  logic clash;

  assign same_word = ctl_v[0].mem_acc && ctl_v[1].mem_acc && (addr_v[0] == addr_v[1]);
  assign clash     = same_word && (ctl_v[0].we || ctl_v[1].we);

  // left port wins every tie
  assign busy_o[0] = 1'b0;
  assign busy_o[1] = master && clash;

  assign block[0] = !master && busy_in[0];
  assign block[1] = master ? clash : busy_in[1];

  assert_read_share_no_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && same_word && !ctl_v[0].we && !ctl_v[1].we) |-> (busy_o == 2'b00));

  assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (busy_o == 2'b00));
endmodule

// File: rtl/dpram_array.sv
module dpram_array
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  port_ctl_t [1:0]            ctl_v,
  input  logic [1:0][ADDR_W-1:0]     addr_v,
  input  logic [1:0][WORD_W-1:0]     wdata_v,
  input  logic [1:0]                 block,
  output logic [1:0][WORD_W-1:0]     rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_hi [DEPTH];
  logic [LANE_W-1:0] mem_lo [DEPTH];
  logic [1:0]        wen;
  logic [1:0]        ren;

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign wen[p] = ctl_v[p].mem_acc && ctl_v[p].we && !block[p];
    assign ren[p] = ctl_v[p].mem_acc && !ctl_v[p].we;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_q[p] <= '0;
      end else if (ren[p]) begin
        rd_q[p] <= {mem_hi[addr_v[p]], mem_lo[addr_v[p]]}
                   & lane_mask(ctl_v[p].ube, ctl_v[p].lbe);
      end
    end

    // a write refused by arbitration leaves the word intact
    assert_blocked_write_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_v[p].mem_acc && ctl_v[p].we && block[p]
       && !(wen[1-p] && addr_v[1-p] == addr_v[p]))
      |=> (mem_hi[$past(addr_v[p])] == $past(mem_hi[addr_v[p]]))
       && (mem_lo[$past(addr_v[p])] == $past(mem_lo[addr_v[p]])));
  end

  // right first, then left, so the left port lands last
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      if (wen[p]) begin
        if (ctl_v[p].ube) mem_hi[addr_v[p]] <= wdata_v[p][WORD_W-1:LANE_W];
        if (ctl_v[p].lbe) mem_lo[addr_v[p]] <= wdata_v[p][LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  port_ctl_t [1:0]            ctl_v,
  input  logic [1:0][ADDR_W-1:0]     addr_v,
  input  logic [1:0]                 block,
  output logic [1:0]                 int_o
);
  localparam int DEPTH = 1 << ADDR_W;
  // word that raises the flag of port p: [0] left, [1] right
  localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'(DEPTH - 1);

  logic [1:0][ADDR_W-1:0] box;
  logic [1:0]             set_v;
  logic [1:0]             clr_v;

  assign box[0] = BOX_L;
  assign box[1] = BOX_R;

  for (genvar p = 0; p < 2; p++) begin : g_flag
    assign set_v[p] = ctl_v[1-p].mem_acc && ctl_v[1-p].we && !block[1-p]
                      && (addr_v[1-p] == box[p]);
    assign clr_v[p] = ctl_v[p].mem_acc && !ctl_v[p].we && (addr_v[p] == box[p]);

    always_ff @(posedge clk) begin
      if (!rst_n)        int_o[p] <= 1'b0;
      else if (set_v[p]) int_o[p] <= 1'b1;
      else if (clr_v[p]) int_o[p] <= 1'b0;
    end

    assert_flag_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[p] |=> int_o[p]);

    assert_flag_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[p] && !set_v[p]) |=> !int_o[p]);
  end
endmodule

// File: rtl/dpram_semaphore.sv
module dpram_semaphore
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  port_ctl_t [1:0]            ctl_v,
  input  logic [1:0][ADDR_W-1:0]     addr_v,
  input  logic [1:0]                 wbit,
  output logic [1:0][WORD_W-1:0]     rd_q
);
  logic [1:0][SEM_N-1:0] own_q;
  logic [1:0][SEM_N-1:0] own_d;
  logic [1:0][SEM_N-1:0] req;
  logic [1:0][SEM_N-1:0] rel;

  for (genvar p = 0; p < 2; p++) begin : g_dec
    for (genvar i = 0; i < SEM_N; i++) begin : g_bit
      logic hit;
      assign hit       = ctl_v[p].sem_acc && ctl_v[p].we
                         && (addr_v[p][SEM_IDX_W-1:0] == SEM_IDX_W'(i));
      assign req[p][i] = hit && !wbit[p];
      assign rel[p][i] = hit && wbit[p];
    end
  end

  always_comb begin
    own_d = own_q & ~rel;
    // left is resolved first and so wins a simultaneous request
    own_d[0] = own_d[0] | (req[0] & ~own_d[1]);
    own_d[1] = own_d[1] | (req[1] & ~own_d[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= '0;
    else        own_q <= own_d;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_q[p] <= '0;
      end else if (ctl_v[p].sem_acc && !ctl_v[p].we) begin
        rd_q[p] <= own_q[p][addr_v[p][SEM_IDX_W-1:0]] ? '0 : WORD_W'(1);
      end
    end
  end

  assert_sem_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q[0] & own_q[1]) == '0);

  assert_sem_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rel[0] != '0 && req[0] == '0) |=> ((own_q[0] & $past(rel[0])) == '0));
endmodule

// File: rtl/dpram_arb_top.sv
module dpram_arb_top
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_master,
  input  logic              l_ce0,
  input  logic              l_ce1,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_ube,
  input  logic              l_lbe,
  input  logic              l_sem,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [15:0]       l_wdata,
  output logic [15:0]       l_rdata,
  input  logic              l_busy_in,
  output logic              l_busy_o,
  output logic              l_int,
  input  logic              r_ce0,
  input  logic              r_ce1,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_ube,
  input  logic              r_lbe,
  input  logic              r_sem,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [15:0]       r_wdata,
  output logic [15:0]       r_rdata,
  input  logic              r_busy_in,
  output logic              r_busy_o,
  output logic              r_int
);
  port_ctl_t [1:0]            ctl_v;
  logic [1:0][ADDR_W-1:0]     addr_v;
  logic [1:0][WORD_W-1:0]     wdata_v;
  logic [1:0]                 ce0_v, ce1_v, we_v, oe_v, ube_v, lbe_v, sem_v;
  logic [1:0]                 busy_in_v, busy_o_v, block_v, int_v, src_sem_q;
  logic [1:0][WORD_W-1:0]     mem_q, sem_q, rdata_v;
  logic [1:0]                 wbit_v;

  assign ce0_v     = {r_ce0, l_ce0};
  assign ce1_v     = {r_ce1, l_ce1};
  assign we_v      = {r_we, l_we};
  assign oe_v      = {r_oe, l_oe};
  assign ube_v     = {r_ube, l_ube};
  assign lbe_v     = {r_lbe, l_lbe};
  assign sem_v     = {r_sem, l_sem};
  assign addr_v    = {r_addr, l_addr};
  assign wdata_v   = {r_wdata, l_wdata};
  assign busy_in_v = {r_busy_in, l_busy_in};

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic sel;
    assign sel              = ce0_v[p] && ce1_v[p];
    assign ctl_v[p].mem_acc = sel && !sem_v[p];
    assign ctl_v[p].sem_acc = sel && sem_v[p];
    assign ctl_v[p].we      = we_v[p];
    assign ctl_v[p].ube     = ube_v[p];
    assign ctl_v[p].lbe     = lbe_v[p];
    assign wbit_v[p]        = wdata_v[p][0];

    // remembers which space the last read came from
    always_ff @(posedge clk) begin
      if (!rst_n)                                  src_sem_q[p] <= 1'b0;
      else if (ctl_v[p].sem_acc && !we_v[p])       src_sem_q[p] <= 1'b1;
      else if (ctl_v[p].mem_acc && !we_v[p])       src_sem_q[p] <= 1'b0;
    end

    assign rdata_v[p] = !oe_v[p] ? '0 : (src_sem_q[p] ? sem_q[p] : mem_q[p]);
  end

  dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .master(mode_master), .ctl_v(ctl_v), .addr_v(addr_v),
    .busy_in(busy_in_v), .busy_o(busy_o_v), .block(block_v));

  dpram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .ctl_v(ctl_v), .addr_v(addr_v), .wdata_v(wdata_v),
    .block(block_v), .rd_q(mem_q));

  dpram_mailbox #(.ADDR_W(ADDR_W)) u_mbox (
    .clk(clk), .rst_n(rst_n), .ctl_v(ctl_v), .addr_v(addr_v), .block(block_v),
    .int_o(int_v));

  dpram_semaphore #(.ADDR_W(ADDR_W)) u_sem (
    .clk(clk), .rst_n(rst_n), .ctl_v(ctl_v), .addr_v(addr_v), .wbit(wbit_v),
    .rd_q(sem_q));

  assign l_rdata  = rdata_v[0];
  assign r_rdata  = rdata_v[1];
  assign l_busy_o = busy_o_v[0];
  assign r_busy_o = busy_o_v[1];
  assign l_int    = int_v[0];
  assign r_int    = int_v[1];

  assert_oe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !l_oe |-> (l_rdata == '0));

  assert_left_never_loses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_master |-> !l_busy_o);
endmodule

// File: tb/tb_dpram_arb_top.sv
module tb_dpram_arb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, mode_master = 1'b1;
  logic l_ce0, l_ce1, l_we, l_oe, l_ube, l_lbe, l_sem, l_busy_in;
  logic r_ce0, r_ce1, r_we, r_oe, r_ube, r_lbe, r_sem, r_busy_in;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_busy_o, r_busy_o, l_int, r_int;

  logic [15:0] model [DEPTH];
  int nvec = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_arb_top #(.ADDR_W(AW)) dut (.*);

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_l(input logic c0, input logic c1, input logic we, input logic sem,
                       input logic ub, input logic lb, input int a, input logic [15:0] d);
    l_ce0 = c0; l_ce1 = c1; l_we = we; l_sem = sem; l_ube = ub; l_lbe = lb;
    l_addr = AW'(a); l_wdata = d;
  endtask

  task automatic set_r(input logic c0, input logic c1, input logic we, input logic sem,
                       input logic ub, input logic lb, input int a, input logic [15:0] d);
    r_ce0 = c0; r_ce1 = c1; r_we = we; r_sem = sem; r_ube = ub; r_lbe = lb;
    r_addr = AW'(a); r_wdata = d;
  endtask

  task automatic idle();
    set_l(0, 0, 0, 0, 1, 1, 0, 0);
    set_r(0, 0, 0, 0, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R13: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    idle(); l_oe = 1; r_oe = 1; l_busy_in = 0; r_busy_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk("R13 l_rdata", l_rdata, 0); chk("R13 r_rdata", r_rdata, 0);
    chk("R13 busy", {14'd0, l_busy_o, r_busy_o}, 0);
    chk("R13 int", {14'd0, l_int, r_int}, 0);

    // fill the array from the left, read back from both ports (R3)
    for (int a = 0; a < DEPTH; a++) begin
      set_l(1, 1, 1, 0, 1, 1, a, pat(a)); model[a] = pat(a); step();
    end
    for (int a = 0; a < DEPTH; a++) begin
      set_r(1, 1, 0, 0, 1, 1, a, 0);
      set_l(1, 1, 0, 0, 1, 1, (a + 7) % DEPTH, 0);
      step();
      chk("R3 right read", r_rdata, model[a]);
      chk("R3 left read", l_rdata, model[(a + 7) % DEPTH]);
    end
    idle();

    // byte lane sweep (R2 writes, R3 masked reads)
    for (int a = 0; a < 16; a++) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [15:0] d, m;
        d = ~pat(a + 64 * ln);
        m = {{8{ln[1]}}, {8{ln[0]}}};
        set_l(1, 1, 1, 0, ln[1], ln[0], a, d);
        model[a] = (model[a] & ~m) | (d & m); step();
        set_l(0, 0, 0, 0, 1, 1, 0, 0);
        set_r(1, 1, 0, 0, 1, 1, a, 0); step();
        chk("R2 lane write", r_rdata, model[a]);
        set_r(1, 1, 0, 0, ln[0], ln[1], a, 0); step();
        chk("R3 lane read", r_rdata, model[a] & {{8{ln[0]}}, {8{ln[1]}}});
        set_r(0, 0, 0, 0, 1, 1, 0, 0);
      end
    end

    // chip enables (R1)
    for (int c = 0; c < 3; c++) begin
      set_l(c[0], c[1], 1, 0, 1, 1, 20, 16'hDEAD); step();
      set_l(0, 0, 0, 0, 1, 1, 0, 0);
      set_r(1, 1, 0, 0, 1, 1, 20, 0); step();
      chk("R1 unselected write", r_rdata, model[20]);
      set_r(c[1], c[0], 0, 0, 1, 1, 21, 0); step();
      chk("R1 unselected read holds", r_rdata, model[20]);
      set_r(0, 0, 0, 0, 1, 1, 0, 0);
    end

    // shared read (R4)
    set_l(1, 1, 0, 0, 1, 1, 30, 0); set_r(1, 1, 0, 0, 1, 1, 30, 0);
    #1 chk("R4 no busy", {14'd0, l_busy_o, r_busy_o}, 0);
    step();
    chk("R4 left", l_rdata, model[30]); chk("R4 right", r_rdata, model[30]);

    // write/write collision (R5)
    set_l(1, 1, 1, 0, 1, 1, 40, 16'hA1A1); set_r(1, 1, 1, 0, 1, 1, 40, 16'hB2B2);
    #1 chk("R5 busy right", {15'd0, r_busy_o}, 1); chk("R5 busy left", {15'd0, l_busy_o}, 0);
    step(); model[40] = 16'hA1A1;
    set_l(0, 0, 0, 0, 1, 1, 0, 0); set_r(1, 1, 0, 0, 1, 1, 40, 0); step();
    chk("R5 left wins", r_rdata, model[40]);

    // right write vs left read (R5 drop, R6 old data)
    set_l(1, 1, 0, 0, 1, 1, 41, 0); set_r(1, 1, 1, 0, 1, 1, 41, 16'h7777);
    #1 chk("R5 busy on read clash", {15'd0, r_busy_o}, 1);
    step(); chk("R6 left old data", l_rdata, model[41]);
    set_r(1, 1, 0, 0, 1, 1, 41, 0); set_l(0, 0, 0, 0, 1, 1, 0, 0); step();
    chk("R5 right write dropped", r_rdata, model[41]);

    // left write vs right read (R6)
    set_l(1, 1, 1, 0, 1, 1, 42, 16'h4242); set_r(1, 1, 0, 0, 1, 1, 42, 0);
    step(); chk("R6 right old data", r_rdata, model[42]); model[42] = 16'h4242;
    set_l(0, 0, 0, 0, 1, 1, 0, 0); step();
    chk("R6 then new data", r_rdata, model[42]);

    // different addresses (R5)
    set_l(1, 1, 1, 0, 1, 1, 43, 16'h1111); set_r(1, 1, 1, 0, 1, 1, 44, 16'h2222);
    #1 chk("R5 no busy apart", {14'd0, l_busy_o, r_busy_o}, 0);
    step(); model[43] = 16'h1111; model[44] = 16'h2222;
    set_l(1, 1, 0, 0, 1, 1, 43, 0); set_r(1, 1, 0, 0, 1, 1, 44, 0); step();
    chk("R5 left stored", l_rdata, model[43]); chk("R5 right stored", r_rdata, model[44]);

    // slave mode (R7)
    mode_master = 0;
    set_l(1, 1, 1, 0, 1, 1, 50, 16'h5050); set_r(1, 1, 1, 0, 1, 1, 50, 16'h5050);
    #1 chk("R7 slave busy low", {14'd0, l_busy_o, r_busy_o}, 0);
    step(); model[50] = 16'h5050;
    r_busy_in = 1; set_l(0, 0, 0, 0, 1, 1, 0, 0); set_r(1, 1, 1, 0, 1, 1, 51, 16'hEEEE); step();
    r_busy_in = 0; l_busy_in = 1;
    set_r(0, 0, 0, 0, 1, 1, 0, 0); set_l(1, 1, 1, 0, 1, 1, 52, 16'hDDDD); step();
    l_busy_in = 0;
    set_l(1, 1, 0, 0, 1, 1, 51, 0); set_r(1, 1, 0, 0, 1, 1, 52, 0); step();
    chk("R7 right blocked", l_rdata, model[51]); chk("R7 left blocked", r_rdata, model[52]);
    set_l(1, 1, 0, 0, 1, 1, 50, 0); step(); chk("R7 free write", l_rdata, model[50]);
    mode_master = 1; idle();

    // output enable (R3)
    set_l(1, 1, 0, 0, 1, 1, 60, 0); l_oe = 0; step();
    chk("R3 oe low", l_rdata, 0);
    set_l(0, 0, 0, 0, 1, 1, 0, 0); l_oe = 1; #1 chk("R3 oe high", l_rdata, model[60]);
    step();

    // mailbox flags (R8, R9)
    set_r(1, 1, 0, 0, 1, 1, DEPTH - 1, 0); set_l(1, 1, 0, 0, 1, 1, DEPTH - 2, 0); step();
    chk("R8 R9 cleared", {14'd0, l_int, r_int}, 0);
    idle(); set_l(1, 1, 1, 0, 1, 1, DEPTH - 1, 16'h0F0F); step();
    chk("R8 right flag set", {14'd0, l_int, r_int}, 16'd1);
    idle(); set_r(1, 1, 0, 0, 1, 1, DEPTH - 1, 0); step();
    chk("R8 right flag clear", {14'd0, l_int, r_int}, 0);
    idle(); set_r(1, 1, 1, 0, 1, 1, DEPTH - 2, 16'hF0F0); step();
    chk("R9 left flag set", {14'd0, l_int, r_int}, 16'd2);
    idle(); set_l(1, 1, 0, 0, 1, 1, DEPTH - 2, 0); step();
    chk("R9 left flag clear", {14'd0, l_int, r_int}, 0);
    idle();

    // semaphores (R10, R11)
    for (int i = 0; i < 8; i++) begin
      set_l(1, 1, 1, 1, 1, 1, i, 16'h0000); step(); idle();
      set_r(1, 1, 1, 1, 1, 1, i, 16'h0000); step(); idle();
      set_l(1, 1, 0, 1, 1, 1, i, 0); set_r(1, 1, 0, 1, 1, 1, i, 0); step();
      chk("R10 left granted", l_rdata, 16'h0000); chk("R10 right refused", r_rdata, 16'h0001);
      idle(); set_l(1, 1, 1, 1, 1, 1, i, 16'h0001); step(); idle();
      set_r(1, 1, 1, 1, 1, 1, i, 16'h0000); step(); idle();
      set_l(1, 1, 0, 1, 1, 1, i, 0); set_r(1, 1, 0, 1, 1, 1, i, 0); step();
      chk("R11 right after release", r_rdata, 16'h0000); chk("R11 left released", l_rdata, 16'h0001);
      idle(); set_r(1, 1, 1, 1, 1, 1, i, 16'h0001); step(); idle();
    end

    // simultaneous request (R12)
    set_l(1, 1, 1, 1, 1, 1, 3, 16'h0000); set_r(1, 1, 1, 1, 1, 1, 3, 16'h0000); step();
    set_l(1, 1, 0, 1, 1, 1, 3, 0); set_r(1, 1, 0, 1, 1, 1, 3, 0); step();
    chk("R12 left wins", l_rdata, 16'h0000); chk("R12 right loses", r_rdata, 16'h0001);
    idle(); step();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule